// File: doc/BRIEF.md
# Bit Error Rate Receive Checker

This block compares a serial bit stream against a reference pattern that it builds on its own. The reference is either a 32-bit repeating word or one of two maximal-length pseudorandom sequences. Before it counts anything, the checker first has to lock onto the incoming stream. Once locked, every accepted bit advances a bit counter and every mismatching bit advances an error counter. The error counter stops at its maximum value instead of wrapping. Runs of all zeros or all ones are detected whether or not the checker is locked.

Six events are captured in a sticky status vector, and an interrupt is raised when any unmasked status bit is set. Received bits arrive on a valid/ready stream. The checker never applies back-pressure, so `rx_ready` stays high and a bit is consumed on every clock edge where `rx_valid` is high. A cycle with `rx_valid` low is simply a gap, which is how positions outside the assigned timeslots are left out. Configuration, counter clearing and status handling use plain level pins.

Top module: `bert_rx_check`

## Requirements
- R1: `cfg_mode` selects the reference pattern. The value 00 selects repetitive mode: the 32-bit `cfg_pattern` repeats, and bit 0 is expected first. The value 01 selects PRBS7 (x^7+x^6+1). The values 10 and 11 select PRBS15 (x^15+x^14+1).
- R2: While unlocked, the checker seeds the PRBS reference from the received bits. In repetitive mode it holds its pattern position for one bit after each mismatch, which slips the alignment by one. `sync` rises after SYNC_RUN (32) consecutive matching accepted bits.
- R3: While locked, LOSS_ERRS (6) mismatches within a LOSS_WIN (64) bit window drop `sync`. Fewer errors per window keep `sync` high.
- R4: `bit_cnt` increments once for each accepted bit while `sync` is high. It wraps at 2^BIT_W. The wrap sets status bit 4.
- R5: `err_cnt` increments once for each mismatching accepted bit while `sync` is high. Both counters hold while `sync` is low.
- R6: `err_cnt` saturates at all ones. Reaching that value sets status bit 3.
- R7: A low-to-high transition of `cnt_clr` clears both counters on that clock edge. The status vector is not affected.
- R8: RUN_LEN (32) consecutive accepted zeros set status bit 1, and 32 consecutive ones set status bit 2. A run of 31 sets neither bit.
- R9: Status bit 0 is set whenever `sync` changes value, and status bit 5 is set on each counted bit error. Status bits are sticky. A high `sts_clr` bit clears the matching status bit, and a new event in the same cycle takes priority over the clear.
- R10: `irq` is high exactly when some status bit is set and its `irq_mask` bit is 0.
- R11: A cycle with `rx_valid` low is ignored by the counters, the lock logic and the run detectors. `rx_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Reference pattern select |
| cfg_pattern | input | PAT_W | Repeating word, bit 0 expected first |
| rx_valid | input | 1 | Received bit present |
| rx_ready | output | 1 | Always high; the checker never stalls |
| rx_data | input | 1 | Received bit |
| cnt_clr | input | 1 | Counter clear on its rising edge |
| sts_clr | input | 6 | Per-bit status clear |
| irq_mask | input | 6 | Per-bit interrupt mask, 1 = masked |
| sync | output | 1 | Pattern lock |
| bit_cnt | output | BIT_W | Accepted-bit counter |
| err_cnt | output | ERR_W | Saturating error counter |
| status | output | 6 | Sticky events {err, bit wrap, err sat, ones, zeros, sync change} |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the checker with BIT_W=10 and ERR_W=4, keeping SYNC_RUN, LOSS_ERRS and LOSS_WIN at their defaults. With these widths the error counter saturates after 15 errors and the bit counter wraps after 1024 locked bits, so both overflow events occur in a short run. The errors are spaced sixteen bits apart, which keeps the stream locked while the counters are exercised. The bench locks in repetitive mode from a misaligned starting offset and in PRBS7 mode after a forced loss of lock, and it tracks both counters bit by bit against its own model.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
  localparam int ST_N     = 6;
  localparam int ST_SYNC  = 0;
  localparam int ST_ZERO  = 1;
  localparam int ST_ONE   = 2;
  localparam int ST_ESAT  = 3;
  localparam int ST_BWRAP = 4;
  localparam int ST_BERR  = 5;
  localparam logic [1:0] MODE_REP   = 2'b00;
  localparam logic [1:0] MODE_PRBS7 = 2'b01;
endpackage

// File: rtl/bert_ref_gen.sv
module bert_ref_gen
  import bert_rx_pkg::*;
#(
  parameter int PAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [PAT_W-1:0] pattern,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             locked,
  output logic             mismatch
);
  localparam int PTR_W  = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam int HIST_W = 15;

  logic [PTR_W-1:0]  ptr;
  logic [HIST_W-1:0] hist;
  logic              exp_bit;

  always_comb begin
    if (mode == MODE_REP)        exp_bit = pattern[ptr];
    else if (mode == MODE_PRBS7) exp_bit = hist[6] ^ hist[5];
    else                         exp_bit = hist[14] ^ hist[13];
  end

  assign mismatch = rx_bit ^ exp_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      hist <= '0;
    end else if (bit_en) begin
      hist <= {hist[HIST_W-2:0], locked ? exp_bit : rx_bit};
      if (locked || !mismatch)
        ptr <= (ptr == PTR_W'(PAT_W-1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/bert_sync_fsm.sv
module bert_sync_fsm #(
  parameter int SYNC_RUN  = 32,
  parameter int LOSS_ERRS = 6,
  parameter int LOSS_WIN  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mismatch,
  output logic locked,
  output logic lock_flip
);
  localparam int RUN_W = $clog2(SYNC_RUN + 1);
  localparam int WIN_W = $clog2(LOSS_WIN + 1);
  localparam int ECW   = $clog2(LOSS_ERRS + 1);

  logic [RUN_W-1:0] run;
  logic [WIN_W-1:0] win;
  logic [ECW-1:0]   errs;
  logic             gain, lose;

  assign gain = bit_en && !locked && !mismatch && (run == RUN_W'(SYNC_RUN-1));
  assign lose = bit_en && locked && mismatch && (errs == ECW'(LOSS_ERRS-1));
  assign lock_flip = gain || lose;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      run    <= '0;
      win    <= '0;
      errs   <= '0;
    end else if (bit_en) begin
      if (!locked) begin
        if (mismatch) run <= '0;
        else if (gain) begin
          locked <= 1'b1;
          run    <= '0;
          win    <= '0;
          errs   <= '0;
        end else run <= run + 1'b1;
      end else if (lose) begin
        locked <= 1'b0;
        run    <= '0;
      end else if (win == WIN_W'(LOSS_WIN-1)) begin
        win  <= '0;
        errs <= '0;
      end else begin
        win  <= win + 1'b1;
        errs <= errs + ECW'(mismatch);
      end
    end
  end
endmodule

// File: rtl/bert_counters.sv
module bert_counters #(
  parameter int BIT_W = 32,
  parameter int ERR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             count_en,
  input  logic             bit_err,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [ERR_W-1:0] err_cnt,
  output logic             bit_wrap,
  output logic             err_full
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  assign bit_wrap = !clr && count_en && (&bit_cnt);
  assign err_full = !clr && count_en && bit_err && (err_cnt == ERR_MAX - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (clr) begin
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (count_en) begin
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_err && err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bert_status.sv
module bert_status #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | evt;
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/bert_rx_check.sv
module bert_rx_check
  import bert_rx_pkg::*;
#(
  parameter int PAT_W     = 32,
  parameter int BIT_W     = 32,
  parameter int ERR_W     = 24,
  parameter int SYNC_RUN  = 32,
  parameter int LOSS_ERRS = 6,
  parameter int LOSS_WIN  = 64,
  parameter int RUN_LEN   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [PAT_W-1:0] cfg_pattern,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic             rx_data,
  input  logic             cnt_clr,
  input  logic [ST_N-1:0]  sts_clr,
  input  logic [ST_N-1:0]  irq_mask,
  output logic             sync,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [ERR_W-1:0] err_cnt,
  output logic [ST_N-1:0]  status,
  output logic             irq
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic             mismatch, lock_flip, bit_wrap, err_full;
  logic             clr_q, clr_edge;
  logic [RUN_W-1:0] zrun, orun;
  logic             zero_evt, one_evt;
  logic [ST_N-1:0]  evt;

  assign rx_ready = 1'b1;

  bert_ref_gen #(.PAT_W(PAT_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .pattern(cfg_pattern),
    .bit_en(rx_valid), .rx_bit(rx_data), .locked(sync), .mismatch(mismatch)
  );

  bert_sync_fsm #(.SYNC_RUN(SYNC_RUN), .LOSS_ERRS(LOSS_ERRS), .LOSS_WIN(LOSS_WIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_valid), .mismatch(mismatch),
    .locked(sync), .lock_flip(lock_flip)
  );

  // counter clear acts on the rising edge of the control level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= cnt_clr;
  end
  assign clr_edge = cnt_clr && !clr_q;

  bert_counters #(.BIT_W(BIT_W), .ERR_W(ERR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_edge), .count_en(sync && rx_valid),
    .bit_err(mismatch), .bit_cnt(bit_cnt), .err_cnt(err_cnt),
    .bit_wrap(bit_wrap), .err_full(err_full)
  );

  // same-value run detectors, independent of lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun <= '0;
      orun <= '0;
    end else if (rx_valid) begin
      if (rx_data) begin
        zrun <= '0;
        if (orun != RUN_W'(RUN_LEN)) orun <= orun + 1'b1;
      end else begin
        orun <= '0;
        if (zrun != RUN_W'(RUN_LEN)) zrun <= zrun + 1'b1;
      end
    end
  end
  assign zero_evt = rx_valid && !rx_data && (zrun == RUN_W'(RUN_LEN-1));
  assign one_evt  = rx_valid &&  rx_data && (orun == RUN_W'(RUN_LEN-1));

  always_comb begin
    evt           = '0;
    evt[ST_SYNC]  = lock_flip;
    evt[ST_ZERO]  = zero_evt;
    evt[ST_ONE]   = one_evt;
    evt[ST_ESAT]  = err_full;
    evt[ST_BWRAP] = bit_wrap;
    evt[ST_BERR]  = sync && rx_valid && mismatch;
  end

  bert_status #(.N(ST_N)) u_sts (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(sts_clr), .mask(irq_mask),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/bert_rx_check_sva.sv
module bert_rx_check_sva #(
  parameter int BIT_W = 32,
  parameter int ERR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             cnt_clr,
  input logic [5:0]       sts_clr,
  input logic             sync,
  input logic [BIT_W-1:0] bit_cnt,
  input logic [ERR_W-1:0] err_cnt,
  input logic [5:0]       status
);
  // R6
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == {ERR_W{1'b1}} && !cnt_clr) |=> err_cnt == {ERR_W{1'b1}});

  // R5
  unsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !cnt_clr) |=> ($stable(err_cnt) && $stable(bit_cnt)));

  // R4
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && rx_valid && !cnt_clr) |=> bit_cnt == $past(bit_cnt) + 1'b1);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !cnt_clr) |=> $stable(bit_cnt));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~sts_clr)) == $past(status & ~sts_clr)));

  // R9
  sync_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> status[0]);

  // R9
  bit_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(err_cnt) && err_cnt != '0) |-> status[5]);
endmodule

bind bert_rx_check bert_rx_check_sva #(.BIT_W(BIT_W), .ERR_W(ERR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .cnt_clr(cnt_clr),
  .sts_clr(sts_clr), .sync(sync), .bit_cnt(bit_cnt), .err_cnt(err_cnt),
  .status(status)
);

// File: tb/test_bert_rx_check.sv
module test_bert_rx_check;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 10;
  localparam int EW = 4;
  localparam logic [31:0] PAT = 32'hC3A5_1E77;

  typedef struct packed {
    logic [BW-1:0] b;
    logic [EW-1:0] e;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_mode = 2'b00;
  logic [31:0]   cfg_pattern = PAT;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic          rx_data = 1'b0;
  logic          cnt_clr = 1'b0;
  logic [5:0]    sts_clr = '0;
  logic [5:0]    irq_mask = '0;
  logic          sync;
  logic [BW-1:0] bit_cnt;
  logic [EW-1:0] err_cnt;
  logic [5:0]    status;
  logic          irq;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   track = 0;
  int   rep_idx = 5;
  logic [6:0] bs = 7'h5A;
  logic [BW-1:0] m_bits = '0;
  logic [EW-1:0] m_errs = '0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bert_rx_check #(.BIT_W(BW), .ERR_W(EW)) i_bert_rx_check (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pattern(cfg_pattern),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .cnt_clr(cnt_clr), .sts_clr(sts_clr), .irq_mask(irq_mask),
    .sync(sync), .bit_cnt(bit_cnt), .err_cnt(err_cnt), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one accepted bit per call, scoreboard entry when tracking
  task automatic send(input logic b, input logic inj);
    exp_t it;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b ^ inj;
    @(posedge clk);
    #1 rx_valid = 1'b0;
    if (track) begin
      m_bits = m_bits + 1'b1;
      if (inj && m_errs != '1) m_errs = m_errs + 1'b1;
      it.b = m_bits;
      it.e = m_errs;
      q.push_back(it);
    end
  endtask

  task automatic send_rep(input logic inj);
    logic b;
    b = PAT[rep_idx];
    rep_idx = (rep_idx + 1) % 32;
    send(b, inj);
  endtask

  task automatic send_prbs(input logic inj);
    logic nb;
    nb = bs[6] ^ bs[5];
    bs = {bs[5:0], nb};
    send(nb, inj);
  endtask

  task automatic pulse_clr();
    @(negedge clk) cnt_clr = 1'b1;
    @(negedge clk) cnt_clr = 1'b0;
    m_bits = '0;
    m_errs = '0;
  endtask

  task automatic clr_status();
    @(negedge clk) sts_clr = '1;
    @(negedge clk) sts_clr = '0;
  endtask

  // monitor: compare counters against the scoreboard
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk("R4 bit_cnt track", 32'(bit_cnt), 32'(it.b));
      chk("R5/R6 err_cnt track", 32'(err_cnt), 32'(it.e));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [EW-1:0] e_hold;
    logic [BW-1:0] b_hold;
    bit lost;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset sync", 32'(sync), 0);
    chk("R4 reset bit_cnt", 32'(bit_cnt), 0);
    chk("R9 reset status", 32'(status), 0);
    chk("R10 reset irq", 32'(irq), 0);
    chk("R11 rx_ready", 32'(rx_ready), 1);

    // R8 zero and one runs, unlocked, REP mode
    for (int i = 0; i < 31; i++) send(1'b0, 1'b0);
    chk("R8 31 zeros no flag", 32'(status[1]), 0);
    send(1'b0, 1'b0);
    chk("R8 32 zeros flag", 32'(status[1]), 1);
    for (int i = 0; i < 31; i++) send(1'b1, 1'b0);
    chk("R8 31 ones no flag", 32'(status[2]), 0);
    send(1'b1, 1'b0);
    chk("R8 32 ones flag", 32'(status[2]), 1);
    chk("R5 unlocked err_cnt held", 32'(err_cnt), 0);
    chk("R10 irq unmasked", 32'(irq), 1);
    clr_status();
    chk("R9 status cleared", 32'(status), 0);
    chk("R10 irq low", 32'(irq), 0);

    // R1/R2 repetitive mode lock from misaligned start
    for (int n = 0; n < 2000 && !sync; n++) send_rep(1'b0);
    chk("R1 R2 repetitive lock", 32'(sync), 1);
    chk("R9 sync change flag", 32'(status[0]), 1);
    pulse_clr();
    chk("R7 clear bit_cnt", 32'(bit_cnt), 0);
    track = 1;
    for (int i = 0; i < 64; i++) send_rep((i == 10) || (i == 40));
    track = 0;
    @(negedge clk);
    chk("R5 two errors", 32'(err_cnt), 2);
    chk("R9 bit error flag", 32'(status[5]), 1);

    // R11 idle cycles with garbage data
    b_hold = bit_cnt;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) rx_data = ~rx_data;
    end
    @(negedge clk);
    chk("R11 idle bit_cnt", 32'(bit_cnt), 32'(b_hold));
    chk("R11 idle sync", 32'(sync), 1);

    // R1 PRBS7: lose lock on mode change, then relock
    clr_status();
    @(negedge clk) cfg_mode = 2'b01;
    lost = 0;
    for (int n = 0; n < 800 && !(lost && sync); n++) begin
      send_prbs(1'b0);
      if (!sync) lost = 1;
    end
    chk("R3 lock lost after mode change", 32'(lost), 1);
    chk("R1 R2 PRBS7 lock", 32'(sync), 1);
    chk("R9 sync change flag prbs", 32'(status[0]), 1);

    // R4/R6 saturation and wrap with sparse errors
    pulse_clr();
    track = 1;
    for (int i = 0; i < 1100; i++) send_prbs((i % 16) == 8);
    track = 0;
    @(negedge clk);
    chk("R3 sparse errors keep lock", 32'(sync), 1);
    chk("R6 err saturated", 32'(err_cnt), 15);
    chk("R6 saturation flag", 32'(status[3]), 1);
    chk("R4 wrap flag", 32'(status[4]), 1);
    chk("R4 wrapped count", 32'(bit_cnt), 1100 - 1024);

    // R10 masking
    @(negedge clk) irq_mask = 6'b110111;
    #1 chk("R10 unmasked sat irq", 32'(irq), 1);
    @(negedge clk) irq_mask = 6'b111111;
    #1 chk("R10 all masked", 32'(irq), 0);

    // R9 single-bit clear
    @(negedge clk) sts_clr = 6'b001000;
    @(negedge clk) sts_clr = '0;
    chk("R9 clear bit3", 32'(status[3]), 0);
    chk("R9 bit4 kept", 32'(status[4]), 1);

    // R3 burst of errors drops lock; R5 counters freeze
    for (int i = 0; i < 6; i++) send_prbs(1'b1);
    chk("R3 lock lost on burst", 32'(sync), 0);
    e_hold = err_cnt;
    b_hold = bit_cnt;
    for (int i = 0; i < 10; i++) send_prbs(1'b1);
    chk("R5 err frozen unlocked", 32'(err_cnt), 32'(e_hold));
    chk("R5 bits frozen unlocked", 32'(bit_cnt), 32'(b_hold));

    // R7 clear edge leaves status
    pulse_clr();
    chk("R7 bit_cnt cleared", 32'(bit_cnt), 0);
    chk("R7 err_cnt cleared", 32'(err_cnt), 0);
    chk("R7 status kept", 32'(status[4]), 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule